// File: doc/BRIEF.md
# Centronics-style parallel handshake port

This block is a byte-wide parallel port that works either as the receiving end or the sending end of a Centronics-style link. A direction bit and a two-bit mode field select one of four behaviours: plain general-purpose pins, transparent transfer with no handshake, interlocked handshake (strobe and acknowledge wait on each other) and pulsed handshake (fixed-width strobe and acknowledge pulses). On the local side, bytes to send enter through a valid/ready pair, and received bytes leave through a valid/consume pair.

As a receiver in pulsed mode, the block raises BUSY when it sees the host's strobe fall. It latches the byte on that event and answers with a low ACK pulse of programmable length. A two-bit release field places the drop of BUSY before the ACK pulse, inside it, after it, or holds BUSY until local software releases it. As a sender, the block drives the byte, waits a programmable setup time, then strobes. An enable bit turns data pin 0 into a BUSY input from the peer and holds each strobe off until that input is seen low. The strobe, acknowledge and pin-0 inputs pass through two-flop synchronizers. Configuration is copied into the working registers only while both directions are idle.

Top module: `par_hs_port`

## Requirements
- R1: Mode code 00 is general-purpose I/O. When sending, all data pins drive `gpio_out` with output enables on. When receiving, the enables are off and `gpio_in` shows the pins two clocks after synchronization. In this mode `stb_out_n` and `ack_out_n` stay high and `busy_out` stays low.
- R2: In mode 01 (transparent) while receiving, a falling `stb_in_n` latches the data pins into `rx_data` and sets `rx_valid`, and BUSY and ACK are not driven. `rx_valid` stays set until `rx_ready` is high for a clock. A byte arriving in the same clock as a consume leaves `rx_valid` set with the new byte.
- R3: In mode 01 while sending, `tx_ready` stays high and each accepted byte appears on `pin_data_out` in the next clock, with no strobe.
- R4: In mode 10 (interlocked) while receiving, a strobe fall raises `busy_out` and pulls `ack_out_n` low together with the byte latch. Both hold until `stb_in_n` returns high, then both release.
- R5: In mode 10 while sending, `stb_out_n` goes low after the setup interval and stays low until `ack_in_n` is seen low, then returns high. `tx_ready` returns only after `ack_in_n` is seen high again.
- R6: In mode 11 (pulsed) while receiving, `ack_out_n` falls two clocks after `busy_out` rises and stays low for max(`cfg_ack_len`, 2) clocks.
- R7: Release code 00: `busy_out` is high for exactly one clock and falls one clock before ACK falls.
- R8: Release code 01: `busy_out` falls one clock after ACK falls, while ACK is still low.
- R9: Release code 10: `busy_out` falls one clock after ACK rises.
- R10: Release code 11: `busy_out` stays high after the ACK pulse until `sw_release` is high for a clock, and falls in the next clock.
- R11: The release code has no effect outside receive pulsed mode. For example, interlocked receive with code 11 still releases BUSY when the strobe rises.
- R12: In mode 11 while sending, with `cfg_busy_en` at 0, `stb_out_n` falls `cfg_setup_len`+2 clocks after the accepting clock and stays low for max(`cfg_stb_len`, 1) clocks. `tx_ready` is low from the accept until the clock in which the strobe rises.
- R13: While sending with `cfg_busy_en` at 1, `pin_data_oe[0]` is 0 in every mode. A strobe only starts two clocks after `pin_data_in[0]` is seen low, so a drop of that pin releases the strobe three clocks later. With `cfg_busy_en` at 0, pin 0 is ignored.
- R14: Changes to the direction, mode and timing inputs take effect only while both directions are idle. A change made in the middle of a transfer leaves that transfer on the old settings.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_tx | input | 1 | 1 = send, 0 = receive |
| cfg_mode | input | 2 | 00 GPIO, 01 transparent, 10 interlocked, 11 pulsed |
| cfg_tmode | input | 2 | BUSY release placement for receive pulsed mode |
| cfg_busy_en | input | 1 | Pin 0 becomes peer BUSY input that gates the strobe |
| cfg_ack_len | input | CW | ACK pulse length in clocks (min 2) |
| cfg_setup_len | input | CW | Data setup clocks before strobe |
| cfg_stb_len | input | CW | Strobe pulse length in clocks (min 1) |
| sw_release | input | 1 | Releases BUSY for release code 11 |
| tx_valid | input | 1 | Local byte to send is present |
| tx_data | input | DW | Local byte to send |
| tx_ready | output | 1 | Port can take a byte |
| rx_valid | output | 1 | Received byte waiting |
| rx_data | output | DW | Received byte |
| rx_ready | input | 1 | Consume the received byte |
| gpio_out | input | DW | Pin values in GPIO send mode |
| gpio_in | output | DW | Synchronized pin values |
| pin_data_in | input | DW | Data pins, input side |
| pin_data_out | output | DW | Data pins, output side |
| pin_data_oe | output | DW | Per-pin output enable |
| stb_in_n | input | 1 | Host strobe, active low |
| stb_out_n | output | 1 | Outgoing strobe, active low |
| ack_in_n | input | 1 | Peer acknowledge, active low |
| ack_out_n | output | 1 | Outgoing acknowledge, active low |
| busy_out | output | 1 | Outgoing BUSY |

## Verification
The collision of interest is a new byte landing in the receive register in the same clock that the local side consumes the previous one. The bench receives a first byte, then starts a second strobe and raises `rx_ready` for one clock at each offset across a short window around the known synchronizer latency, so exactly one offset hits the arrival clock. Offsets at or before arrival must leave `rx_valid` set with the second byte. The offset after arrival must leave it clear, which separates a correct set-over-clear priority from the reverse.

// File: rtl/par_hs_pkg.sv
package par_hs_pkg;
  typedef enum logic [1:0] {
    HS_GPIO   = 2'b00,
    HS_TRANSP = 2'b01,
    HS_ILOCK  = 2'b10,
    HS_PULSE  = 2'b11
  } hs_mode_e;

  typedef enum logic [1:0] {
    BR_BEFORE = 2'b00,
    BR_DURING = 2'b01,
    BR_AFTER  = 2'b10,
    BR_SOFT   = 2'b11
  } busy_rel_e;

  // Clamp a programmed length to a floor.
  function automatic int unsigned at_least(input int unsigned v, input int unsigned lo);
    return (v < lo) ? lo : v;
  endfunction
endpackage

// File: rtl/par_hs_sync.sv
module par_hs_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= RST_VAL;
      q    <= RST_VAL;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/par_hs_rx.sv
module par_hs_rx
  import par_hs_pkg::*;
#(
  parameter int DW = 8,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  hs_mode_e      mode,
  input  busy_rel_e     rel,
  input  logic [CW-1:0] ack_len,
  input  logic          sw_release,
  input  logic          stb_s,
  input  logic [DW-1:0] data_s,
  input  logic          rx_ready,
  output logic          rx_valid,
  output logic [DW-1:0] rx_data,
  output logic          busy_out,
  output logic          ack_out_n,
  output logic          idle,
  output logic          evt
);
  typedef enum logic [2:0] {
    R_IDLE, R_B1, R_B2, R_ACK, R_TAIL, R_HOLD, R_ILK
  } rx_st_e;

  rx_st_e        st;
  logic          stb_q;
  logic          first;
  logic [CW-1:0] cnt;
  logic [CW-1:0] ack_last;

  assign ack_last = CW'(at_least(32'(ack_len), 2) - 1);
  assign evt      = en && (mode != HS_GPIO) && (st == R_IDLE) && stb_q && !stb_s;
  assign idle     = (st == R_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= R_IDLE;
      stb_q     <= 1'b1;
      first     <= 1'b0;
      cnt       <= '0;
      busy_out  <= 1'b0;
      ack_out_n <= 1'b1;
      rx_valid  <= 1'b0;
      rx_data   <= '0;
    end else begin
      stb_q <= stb_s;
      // arrival wins over a consume in the same clock
      if (evt) begin
        rx_data  <= data_s;
        rx_valid <= 1'b1;
      end else if (rx_ready) begin
        rx_valid <= 1'b0;
      end
      case (st)
        R_IDLE: begin
          if (evt && mode == HS_PULSE) begin
            busy_out <= 1'b1;
            st       <= R_B1;
          end else if (evt && mode == HS_ILOCK) begin
            busy_out  <= 1'b1;
            ack_out_n <= 1'b0;
            st        <= R_ILK;
          end
        end
        R_ILK: begin
          if (stb_s) begin
            busy_out  <= 1'b0;
            ack_out_n <= 1'b1;
            st        <= R_IDLE;
          end
        end
        R_B1: begin
          if (rel == BR_BEFORE) busy_out <= 1'b0;
          st <= R_B2;
        end
        R_B2: begin
          ack_out_n <= 1'b0;
          cnt       <= ack_last;
          first     <= 1'b1;
          st        <= R_ACK;
        end
        R_ACK: begin
          first <= 1'b0;
          if (first && rel == BR_DURING) busy_out <= 1'b0;
          if (cnt == '0) begin
            ack_out_n <= 1'b1;
            st        <= R_TAIL;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        R_TAIL: begin
          if (rel == BR_AFTER) busy_out <= 1'b0;
          st <= (rel == BR_SOFT) ? R_HOLD : R_IDLE;
        end
        R_HOLD: begin
          if (sw_release) begin
            busy_out <= 1'b0;
            st       <= R_IDLE;
          end
        end
        default: st <= R_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/par_hs_tx.sv
module par_hs_tx
  import par_hs_pkg::*;
#(
  parameter int DW = 8,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  hs_mode_e      mode,
  input  logic          busy_en,
  input  logic [CW-1:0] setup_len,
  input  logic [CW-1:0] stb_len,
  input  logic          tx_valid,
  input  logic [DW-1:0] tx_data,
  output logic          tx_ready,
  input  logic          busy_s,
  input  logic          ack_s,
  output logic [DW-1:0] data_q,
  output logic          stb_out_n,
  output logic          idle,
  output logic          acc,
  output logic          stb_go
);
  typedef enum logic [2:0] {T_IDLE, T_SETUP, T_WAITB, T_STB, T_WREL} tx_st_e;

  tx_st_e        st;
  logic [CW-1:0] cnt;
  logic [CW-1:0] stb_last;

  assign stb_last = CW'(at_least(32'(stb_len), 1) - 1);
  assign tx_ready = en && (mode != HS_GPIO) && (st == T_IDLE);
  assign acc      = tx_valid && tx_ready;
  assign stb_go   = (st == T_WAITB) && (!busy_en || !busy_s);
  assign idle     = (st == T_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= T_IDLE;
      cnt       <= '0;
      data_q    <= '0;
      stb_out_n <= 1'b1;
    end else begin
      case (st)
        T_IDLE: begin
          if (acc) begin
            data_q <= tx_data;
            if (mode != HS_TRANSP) begin
              cnt <= setup_len;
              st  <= T_SETUP;
            end
          end
        end
        T_SETUP: begin
          if (cnt == '0) st <= T_WAITB;
          else           cnt <= cnt - 1'b1;
        end
        T_WAITB: begin
          if (stb_go) begin
            stb_out_n <= 1'b0;
            cnt       <= stb_last;
            st        <= T_STB;
          end
        end
        T_STB: begin
          if (mode == HS_ILOCK) begin
            if (!ack_s) begin
              stb_out_n <= 1'b1;
              st        <= T_WREL;
            end
          end else if (cnt == '0) begin
            stb_out_n <= 1'b1;
            st        <= T_IDLE;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        T_WREL: begin
          if (ack_s) st <= T_IDLE;
        end
        default: st <= T_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/par_hs_port.sv
module par_hs_port
  import par_hs_pkg::*;
#(
  parameter int DW = 8,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_tx,
  input  logic [1:0]    cfg_mode,
  input  logic [1:0]    cfg_tmode,
  input  logic          cfg_busy_en,
  input  logic [CW-1:0] cfg_ack_len,
  input  logic [CW-1:0] cfg_setup_len,
  input  logic [CW-1:0] cfg_stb_len,
  input  logic          sw_release,
  input  logic          tx_valid,
  input  logic [DW-1:0] tx_data,
  output logic          tx_ready,
  output logic          rx_valid,
  output logic [DW-1:0] rx_data,
  input  logic          rx_ready,
  input  logic [DW-1:0] gpio_out,
  output logic [DW-1:0] gpio_in,
  input  logic [DW-1:0] pin_data_in,
  output logic [DW-1:0] pin_data_out,
  output logic [DW-1:0] pin_data_oe,
  input  logic          stb_in_n,
  output logic          stb_out_n,
  input  logic          ack_in_n,
  output logic          ack_out_n,
  output logic          busy_out
);
  localparam logic [DW-1:0] ALL_ON = '1;
  localparam logic [DW-1:0] PIN0   = DW'(1);

  // working copy of the configuration
  logic          act_tx;
  hs_mode_e      act_mode;
  busy_rel_e     act_tmode;
  logic          act_busy_en;
  logic [CW-1:0] act_ack_len;
  logic [CW-1:0] act_setup_len;
  logic [CW-1:0] act_stb_len;

  // named internal events
  logic          stb_s;
  logic          ack_s;
  logic          busy_s;
  logic [DW-1:0] data_s;
  logic          rx_idle;
  logic          tx_idle;
  logic          rx_evt;
  logic          tx_acc;
  logic          stb_go;
  logic          eng_idle;
  logic          cfg_upd;
  logic [DW-1:0] tx_q;

  par_hs_sync #(.W(1), .RST_VAL(1'b1)) u_sync_stb (
    .clk(clk), .rst_n(rst_n), .d(stb_in_n), .q(stb_s)
  );
  par_hs_sync #(.W(1), .RST_VAL(1'b1)) u_sync_ack (
    .clk(clk), .rst_n(rst_n), .d(ack_in_n), .q(ack_s)
  );
  par_hs_sync #(.W(DW), .RST_VAL('0)) u_sync_dat (
    .clk(clk), .rst_n(rst_n), .d(pin_data_in), .q(data_s)
  );

  assign busy_s   = data_s[0];
  assign eng_idle = rx_idle && tx_idle;
  assign cfg_upd  = eng_idle && !rx_evt && !tx_acc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_tx        <= 1'b0;
      act_mode      <= HS_GPIO;
      act_tmode     <= BR_BEFORE;
      act_busy_en   <= 1'b0;
      act_ack_len   <= '0;
      act_setup_len <= '0;
      act_stb_len   <= '0;
    end else if (cfg_upd) begin
      act_tx        <= cfg_tx;
      act_mode      <= hs_mode_e'(cfg_mode);
      act_tmode     <= busy_rel_e'(cfg_tmode);
      act_busy_en   <= cfg_busy_en;
      act_ack_len   <= cfg_ack_len;
      act_setup_len <= cfg_setup_len;
      act_stb_len   <= cfg_stb_len;
    end
  end

  par_hs_rx #(.DW(DW), .CW(CW)) u_rx (
    .clk(clk), .rst_n(rst_n), .en(!act_tx), .mode(act_mode), .rel(act_tmode),
    .ack_len(act_ack_len), .sw_release(sw_release), .stb_s(stb_s), .data_s(data_s),
    .rx_ready(rx_ready), .rx_valid(rx_valid), .rx_data(rx_data), .busy_out(busy_out),
    .ack_out_n(ack_out_n), .idle(rx_idle), .evt(rx_evt)
  );

  par_hs_tx #(.DW(DW), .CW(CW)) u_tx (
    .clk(clk), .rst_n(rst_n), .en(act_tx), .mode(act_mode), .busy_en(act_busy_en),
    .setup_len(act_setup_len), .stb_len(act_stb_len), .tx_valid(tx_valid),
    .tx_data(tx_data), .tx_ready(tx_ready), .busy_s(busy_s), .ack_s(ack_s),
    .data_q(tx_q), .stb_out_n(stb_out_n), .idle(tx_idle), .acc(tx_acc), .stb_go(stb_go)
  );

  assign pin_data_out = (act_mode == HS_GPIO) ? gpio_out : tx_q;
  assign pin_data_oe  = !act_tx ? '0 : (act_busy_en ? (ALL_ON & ~PIN0) : ALL_ON);
  assign gpio_in      = data_s;
endmodule

// File: rtl/par_hs_chk.sv
module par_hs_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          act_tx,
  input logic [1:0]    act_mode,
  input logic [1:0]    act_tmode,
  input logic          act_busy_en,
  input logic          eng_idle,
  input logic          rx_evt,
  input logic          rx_valid,
  input logic          busy_out,
  input logic          ack_out_n,
  input logic          stb_out_n,
  input logic          busy_s,
  input logic [DW-1:0] pin_data_oe,
  input logic          tx_acc,
  input logic          tx_ready
);
  logic rx_pulse;
  assign rx_pulse = !act_tx && (act_mode == 2'b11);

  // R1
  gpio_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_mode == 2'b00) |-> (!busy_out && ack_out_n && stb_out_n));

  // R2
  rx_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_evt |=> rx_valid);

  // R7
  rel_before_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_pulse && act_tmode == 2'b00 && $fell(ack_out_n)) |-> !busy_out);

  // R8
  rel_during_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_pulse && act_tmode == 2'b01 && $fell(ack_out_n)) |-> busy_out);

  // R8
  rel_during_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_pulse && act_tmode == 2'b01 && $rose(ack_out_n)) |-> !busy_out);

  // R9
  rel_after_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_pulse && act_tmode == 2'b10 && $rose(ack_out_n)) |-> busy_out ##1 !busy_out);

  // R12
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_acc && act_mode != 2'b01) |=> !tx_ready);

  // R13
  pin0_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_tx && act_busy_en) |-> !pin_data_oe[0]);

  // R13
  stb_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(stb_out_n) && act_tx && act_busy_en) |-> !$past(busy_s));

  // R14
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !eng_idle |=> ($stable(act_mode) && $stable(act_tx) && $stable(act_tmode)));
endmodule

bind par_hs_port par_hs_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .act_tx(act_tx), .act_mode(act_mode),
  .act_tmode(act_tmode), .act_busy_en(act_busy_en), .eng_idle(eng_idle),
  .rx_evt(rx_evt), .rx_valid(rx_valid), .busy_out(busy_out), .ack_out_n(ack_out_n),
  .stb_out_n(stb_out_n), .busy_s(busy_s), .pin_data_oe(pin_data_oe),
  .tx_acc(tx_acc), .tx_ready(tx_ready)
);

// File: tb/sim_par_hs_port.sv
module sim_par_hs_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_tx = 1'b0;
  logic [1:0] cfg_mode = 2'b00;
  logic [1:0] cfg_tmode = 2'b00;
  logic       cfg_busy_en = 1'b0;
  logic [7:0] cfg_ack_len = 8'd2;
  logic [7:0] cfg_setup_len = 8'd0;
  logic [7:0] cfg_stb_len = 8'd1;
  logic       sw_release = 1'b0;
  logic       tx_valid = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic       tx_ready;
  logic       rx_valid;
  logic [7:0] rx_data;
  logic       rx_ready = 1'b0;
  logic [7:0] gpio_out = 8'h00;
  logic [7:0] gpio_in;
  logic [7:0] pin_data_in = 8'h00;
  logic [7:0] pin_data_out;
  logic [7:0] pin_data_oe;
  logic       stb_in_n = 1'b1;
  logic       stb_out_n;
  logic       ack_in_n = 1'b1;
  logic       ack_out_n;
  logic       busy_out;

  int n_cmp = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  par_hs_port #(.DW(8), .CW(8)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_tx(cfg_tx), .cfg_mode(cfg_mode), .cfg_tmode(cfg_tmode),
    .cfg_busy_en(cfg_busy_en), .cfg_ack_len(cfg_ack_len), .cfg_setup_len(cfg_setup_len),
    .cfg_stb_len(cfg_stb_len), .sw_release(sw_release), .tx_valid(tx_valid),
    .tx_data(tx_data), .tx_ready(tx_ready), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_ready(rx_ready), .gpio_out(gpio_out), .gpio_in(gpio_in), .pin_data_in(pin_data_in),
    .pin_data_out(pin_data_out), .pin_data_oe(pin_data_oe), .stb_in_n(stb_in_n),
    .stb_out_n(stb_out_n), .ack_in_n(ack_in_n), .ack_out_n(ack_out_n), .busy_out(busy_out)
  );

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", rq, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setcfg(input bit tx, input int m, input int tm, input bit be,
                        input int al, input int su, input int sw);
    cfg_tx = tx; cfg_mode = 2'(m); cfg_tmode = 2'(tm); cfg_busy_en = be;
    cfg_ack_len = 8'(al); cfg_setup_len = 8'(su); cfg_stb_len = 8'(sw);
    cyc(4);
  endtask

  task automatic consume();
    rx_ready = 1'b1; cyc(1); rx_ready = 1'b0;
  endtask

  // Accept a byte; returns at the sample point just after the accepting edge (k = 0).
  task automatic tx_send(input logic [7:0] b);
    while (!tx_ready) @(negedge clk);
    tx_data = b; tx_valid = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  // Strobe one byte in and measure the pulsed receive handshake.
  task automatic rx_pulse_run(input int tm, input int len, input logic [7:0] b);
    int br = -1, af = -1, ar = -1, bf = -1;
    int wl = (len < 2) ? 2 : len;
    pin_data_in = b; stb_in_n = 1'b0;
    for (int k = 1; k <= 60; k++) begin
      @(negedge clk);
      if (br < 0 && busy_out) br = k;
      if (br >= 0 && bf < 0 && !busy_out) bf = k;
      if (af < 0 && !ack_out_n) af = k;
      if (af >= 0 && ar < 0 && ack_out_n) ar = k;
      if (k == 4) stb_in_n = 1'b1;
    end
    chk(af == br + 2, "R6 ack fall after busy", af - br, 2);
    chk(ar - af == wl, "R6 ack width", ar - af, wl);
    chk(rx_valid && rx_data == b, "R6 byte latched", int'(rx_data), int'(b));
    if (tm == 0) chk(bf == br + 1, "R7 busy before ack", bf - br, 1);
    if (tm == 1) chk(bf == af + 1 && bf < ar, "R8 busy during ack", bf - af, 1);
    if (tm == 2) chk(bf == ar + 1, "R9 busy after ack", bf - ar, 1);
    consume();
  endtask

  task automatic tx_pulse_run(input int su, input int sw, input logic [7:0] b);
    int fl = -1, fh = -1, kr = -1;
    int wl = (sw < 1) ? 1 : sw;
    tx_send(b);
    chk(pin_data_out == b, "R12 data driven", int'(pin_data_out), int'(b));
    for (int k = 0; k <= 40; k++) begin
      if (fl < 0 && !stb_out_n) fl = k;
      if (fl >= 0 && fh < 0 && stb_out_n) fh = k;
      if (kr < 0 && tx_ready) kr = k;
      @(negedge clk);
    end
    chk(fl == su + 2, "R12 strobe start", fl, su + 2);
    chk(fh - fl == wl, "R12 strobe width", fh - fl, wl);
    chk(kr == fh, "R12 ready after strobe", kr, fh);
  endtask

  initial begin : main
    logic [7:0] pat;
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    // reset state
    chk(!busy_out && ack_out_n && stb_out_n, "R1 reset handshake idle", int'(busy_out), 0);
    chk(!rx_valid && pin_data_oe == 8'h00, "R1 reset outputs", int'(pin_data_oe), 0);

    // R1 GPIO send and receive
    for (int i = 0; i < 8; i++) begin
      pat = 8'(8'h5A ^ (8'h01 << i));
      gpio_out = pat;
      setcfg(1, 0, 0, 0, 2, 0, 1);
      chk(pin_data_out == pat && pin_data_oe == 8'hFF, "R1 gpio send", int'(pin_data_out), int'(pat));
      chk(stb_out_n && ack_out_n && !busy_out, "R1 gpio quiet", int'(stb_out_n), 1);
      setcfg(0, 0, 0, 0, 2, 0, 1);
      pin_data_in = ~pat;
      cyc(3);
      chk(gpio_in == ~pat && pin_data_oe == 8'h00, "R1 gpio read", int'(gpio_in), int'(~pat));
    end
    setcfg(1, 0, 0, 1, 2, 0, 1);
    chk(pin_data_oe == 8'hFE, "R13 pin0 released in gpio", int'(pin_data_oe), 'hFE);

    // R2 transparent receive
    setcfg(0, 1, 3, 0, 2, 0, 1);
    pin_data_in = 8'hC3; stb_in_n = 1'b0;
    cyc(5);
    chk(rx_valid && rx_data == 8'hC3, "R2 transparent latch", int'(rx_data), 'hC3);
    chk(busy_out == 1'b0 && ack_out_n, "R2 no busy or ack", int'(busy_out), 0);
    stb_in_n = 1'b1; cyc(6);
    chk(rx_valid, "R2 valid holds", int'(rx_valid), 1);
    consume();
    chk(!rx_valid, "R2 consumed", int'(rx_valid), 0);

    // R2 arrival versus consume, offset sweep
    for (int d = 0; d <= 3; d++) begin
      pin_data_in = 8'h11; stb_in_n = 1'b0; cyc(4); stb_in_n = 1'b1; cyc(4);
      pin_data_in = 8'(8'h20 + d); stb_in_n = 1'b0;
      for (int j = 0; j <= 5; j++) begin
        rx_ready = (j == d);
        @(negedge clk);
      end
      rx_ready = 1'b0;
      chk(rx_valid == (d <= 2), "R2 arrival vs consume", int'(rx_valid), int'(d <= 2));
      chk(rx_data == 8'(8'h20 + d), "R2 second byte kept", int'(rx_data), 'h20 + d);
      stb_in_n = 1'b1; cyc(4);
      if (rx_valid) consume();
    end

    // R3 transparent send
    setcfg(1, 1, 0, 0, 2, 3, 3);
    tx_valid = 1'b1;
    for (int i = 0; i < 6; i++) begin
      tx_data = 8'(8'h31 * (i + 1));
      @(negedge clk);
      chk(pin_data_out == 8'(8'h31 * (i + 1)) && tx_ready && stb_out_n,
          "R3 transparent byte", int'(pin_data_out), 8'h31 * (i + 1));
    end
    tx_valid = 1'b0;

    // R4 and R11 interlocked receive, release code must not matter
    for (int tm = 0; tm < 4; tm += 3) begin
      setcfg(0, 2, tm, 0, 2, 0, 1);
      pin_data_in = 8'(8'h70 + tm); stb_in_n = 1'b0;
      cyc(12);
      chk(busy_out && !ack_out_n && rx_data == 8'(8'h70 + tm), "R4 interlocked hold",
          int'(ack_out_n), 0);
      stb_in_n = 1'b1; cyc(4);
      chk(!busy_out && ack_out_n, "R11 release on strobe rise", int'(busy_out), 0);
      consume();
    end

    // R6..R9 pulsed receive sweep
    for (int tm = 0; tm < 3; tm++) begin
      for (int len = 1; len <= 5; len += 2) begin
        setcfg(0, 3, tm, 0, len, 0, 1);
        rx_pulse_run(tm, len, 8'(8'h90 + tm * 8 + len));
      end
    end

    // R10 software release
    setcfg(0, 3, 3, 0, 3, 0, 1);
    pin_data_in = 8'hE7; stb_in_n = 1'b0; cyc(4); stb_in_n = 1'b1; cyc(30);
    chk(busy_out && ack_out_n, "R10 busy held", int'(busy_out), 1);
    sw_release = 1'b1; cyc(1); sw_release = 1'b0;
    chk(!busy_out, "R10 released", int'(busy_out), 0);
    consume();

    // R12 pulsed send sweep
    for (int su = 0; su <= 3; su += 3) begin
      for (int sw = 0; sw <= 4; sw += 2) begin
        setcfg(1, 3, 0, 0, 2, su, sw);
        tx_pulse_run(su, sw, 8'(8'hA0 + su * 5 + sw));
      end
    end

    // R13 busy gating
    setcfg(1, 3, 0, 0, 2, 0, 2);
    pin_data_in = 8'h01;
    tx_pulse_run(0, 2, 8'hB4);
    setcfg(1, 3, 0, 1, 2, 0, 2);
    begin
      int fl = -1;
      tx_send(8'hB6);
      for (int k = 0; k <= 30; k++) begin
        if (fl < 0 && !stb_out_n) fl = k;
        if (k == 15) pin_data_in = 8'h00;
        @(negedge clk);
      end
      chk(pin_data_oe[0] == 1'b0, "R13 pin0 input", int'(pin_data_oe[0]), 0);
      chk(fl == 18, "R13 strobe waits for busy", fl, 18);
    end

    // R5 interlocked send
    setcfg(1, 2, 0, 0, 2, 1, 1);
    tx_send(8'h5C);
    cyc(10);
    chk(!stb_out_n, "R5 strobe held for ack", int'(stb_out_n), 0);
    ack_in_n = 1'b0; cyc(4);
    chk(stb_out_n && !tx_ready, "R5 strobe ends, ack pending", int'(tx_ready), 0);
    ack_in_n = 1'b1; cyc(4);
    chk(tx_ready, "R5 ready after ack release", int'(tx_ready), 1);

    // R14 mode change mid-transfer
    setcfg(1, 3, 0, 0, 2, 0, 8);
    gpio_out = 8'h00;
    tx_send(8'hD2);
    cyc(4);
    cfg_mode = 2'b00;
    cyc(2);
    chk(!stb_out_n && pin_data_out == 8'hD2, "R14 transfer unchanged", int'(pin_data_out), 'hD2);
    cyc(4);
    chk(stb_out_n, "R14 strobe ends on old width", int'(stb_out_n), 1);
    cyc(4);
    chk(pin_data_out == 8'h00, "R14 new mode applied", int'(pin_data_out), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule